// File: doc/BRIEF.md
# Exception Entry and Vectoring Unit

This unit handles exception entry for a 32-bit processor pipeline. Each cycle it accepts a set of raised exception causes, the program counter of the faulting instruction and an external interrupt line. When at least one cause is active, it picks one cause and starts the entry sequence. The program counter is saved into one of two link registers, the interrupt-enable status bits are updated, and a redirect strobe is issued together with the new fetch address.

Causes fall into two classes. Breakpoint and watchpoint are debug causes. They link through the breakpoint-address register, save the global enable into the breakpoint-saved bit, and always vector from the debug base. All other causes are normal. They link through the exception-address register and save the global enable into the exception-saved bit. They vector from the normal base, or from the debug base when the remap control bit is set. The vector is the selected base plus the cause index times 32.

Two base registers, a control bit and the status bits are loaded through a single write port. Two return strobes restore the global enable from one of the saved bits.

Top module: `trap_entry_unit`

## Requirements
- R1: A normal cause saves `pc_in` into `ea_out`, and `ba_out` keeps its value. The normal causes are instruction bus error (index 2), data bus error (index 4), divide by zero (index 5), external interrupt (index 6) and system call (index 7).
- R2: A debug cause saves `pc_in` into `ba_out`, and `ea_out` keeps its value. The debug causes are breakpoint (index 1) and watchpoint (index 3).
- R3: On normal entry, the old global enable (`status_out[0]`) is copied into the exception-saved bit (`status_out[1]`), and the global enable is cleared. The breakpoint-saved bit (`status_out[2]`) is unchanged.
- R4: On debug entry, the old global enable is copied into `status_out[2]` and the global enable is cleared. `status_out[1]` is unchanged.
- R5: The cycle after a cause is accepted, `redirect_valid` is high for exactly one cycle. In that cycle `redirect_pc` equals the selected base plus the index times 32.
- R6: Debug causes always use the debug base. Normal causes use the normal base while the remap bit is 0, and the debug base while it is 1.
- R7: The external interrupt `irq_in` is taken only while the global enable is 1. Request bits `exc_req[0]` and `exc_req[6]` have no effect.
- R8: When several causes are active in the same cycle, the lowest index is serviced. All other causes in that cycle are dropped.
- R9: A write to either base register forces its low 8 bits to zero. A request in the same cycle as the write still uses the old base. The new base applies from the next cycle onward.
- R10: `eret` loads the global enable from `status_out[1]`. `bret` loads it from `status_out[2]`. If both are high, `eret` wins. An accepted cause in the same cycle overrides both.
- R11: After reset, all outputs are zero.
- R12: Writes go through `csr_wr_sel`: 0 selects the normal base, 1 the debug base, 2 the control register (the remap bit is bit 0), and 3 the status bits (bits [2:0] map to `status_out`). A status write is dropped when a cause is accepted or a return strobe is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 8 | Raised causes, one bit per index |
| irq_in | input | 1 | External interrupt line |
| pc_in | input | 32 | Program counter of the faulting instruction |
| eret | input | 1 | Return from normal exception |
| bret | input | 1 | Return from debug exception |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_sel | input | 2 | Register select |
| csr_wr_data | input | 32 | Register write data |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | 32 | New fetch address |
| ea_out | output | 32 | Exception-address link register |
| ba_out | output | 32 | Breakpoint-address link register |
| status_out | output | 3 | {breakpoint-saved, exception-saved, global enable} |

## Verification
Every result has one cycle of latency. Inputs present before a clock edge produce the redirect strobe, vector, link registers and status bits after that edge. Register writes and return strobes follow the same timing. The bench drives each stimulus on a falling edge and samples all outputs on the next falling edge, one full edge after the input was registered. It then drops the inputs at once, so each strobe is checked to be low again in the following step.

// File: rtl/trap_pkg.sv
package trap_pkg;

  // cause indices; the vector offset depends on them
  localparam int unsigned IDX_RESET = 0;
  localparam int unsigned IDX_BKPT  = 1;
  localparam int unsigned IDX_IBUS  = 2;
  localparam int unsigned IDX_WATCH = 3;
  localparam int unsigned IDX_DBUS  = 4;
  localparam int unsigned IDX_DIV0  = 5;
  localparam int unsigned IDX_IRQ   = 6;
  localparam int unsigned IDX_SCALL = 7;

  typedef enum logic [1:0] {
    SEL_NBASE = 2'd0,
    SEL_DBASE = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_STAT  = 2'd3
  } csr_sel_e;

  typedef struct packed {
    logic bsave;
    logic esave;
    logic gie;
  } stat_t;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
  parameter int unsigned NCAUSE = 8,
  localparam int unsigned IDX_W = $clog2(NCAUSE)
) (
  input  logic [NCAUSE-1:0] req,
  output logic              grant_vld,
  output logic [IDX_W-1:0]  grant_idx
);

  logic [NCAUSE-1:0] blocked;
  logic [NCAUSE-1:0] grant_oh;

  for (genvar i = 0; i < NCAUSE; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign blocked[i] = 1'b0;
    end else begin : g_rest
      assign blocked[i] = blocked[i-1] | req[i-1];
    end
    assign grant_oh[i] = req[i] & ~blocked[i];
  end

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < NCAUSE; i++) begin
      if (grant_oh[i]) grant_idx = grant_idx | IDX_W'(i);
    end
  end

  assign grant_vld = |req;

endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned NCAUSE    = 8,
  parameter int unsigned VEC_SHIFT = 5,
  localparam int unsigned IDX_W    = $clog2(NCAUSE)
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             is_dbg,
  input  logic             remap,
  input  logic [XLEN-1:0]  nbase,
  input  logic [XLEN-1:0]  dbase,
  output logic [XLEN-1:0]  vec_pc
);

  logic [XLEN-1:0] base_sel;
  logic [XLEN-1:0] offset;

  always_comb begin
    base_sel = (is_dbg || remap) ? dbase : nbase;
    offset   = XLEN'(idx) << VEC_SHIFT;
    vec_pc   = base_sel + offset;
  end

endmodule

// File: rtl/trap_csr_bank.sv
module trap_csr_bank
  import trap_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned BASE_ALIGN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [XLEN-1:0] wr_data,
  input  logic            take,
  input  logic            take_dbg,
  input  logic            eret,
  input  logic            bret,
  output logic [XLEN-1:0] nbase,
  output logic [XLEN-1:0] dbase,
  output logic            remap,
  output stat_t           stat
);

  localparam logic [XLEN-1:0] BASE_MASK = ~((XLEN'(1) << BASE_ALIGN) - XLEN'(1));

  logic [XLEN-1:0] nbase_q, nbase_d, dbase_q, dbase_d;
  logic            remap_q, remap_d;
  stat_t           stat_q, stat_d;
  logic            nbase_en, dbase_en, remap_en, stat_en;
  logic            unused_wr;

  assign unused_wr = ^wr_data[BASE_ALIGN-1:3];

  // next state
  always_comb begin
    nbase_en = wr_en && (wr_sel == SEL_NBASE);
    dbase_en = wr_en && (wr_sel == SEL_DBASE);
    remap_en = wr_en && (wr_sel == SEL_CTRL);
    stat_en  = take || eret || bret || (wr_en && (wr_sel == SEL_STAT));

    nbase_d = wr_data & BASE_MASK;
    dbase_d = wr_data & BASE_MASK;
    remap_d = wr_data[0];

    stat_d = stat_q;
    if (take) begin
      if (take_dbg) stat_d.bsave = stat_q.gie;
      else          stat_d.esave = stat_q.gie;
      stat_d.gie = 1'b0;
    end else if (eret) begin
      stat_d.gie = stat_q.esave;
    end else if (bret) begin
      stat_d.gie = stat_q.bsave;
    end else begin
      stat_d = stat_t'(wr_data[2:0]);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbase_q <= '0;
      dbase_q <= '0;
      remap_q <= 1'b0;
      stat_q  <= '0;
    end else begin
      if (nbase_en) nbase_q <= nbase_d;
      if (dbase_en) dbase_q <= dbase_d;
      if (remap_en) remap_q <= remap_d;
      if (stat_en)  stat_q  <= stat_d;
    end
  end

  assign nbase = nbase_q;
  assign dbase = dbase_q;
  assign remap = remap_q;
  assign stat  = stat_q;

  AST_NBASE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_NBASE) |=> nbase_q == ($past(wr_data) & BASE_MASK)); // R9
  AST_ERET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !take) |=> stat_q.gie == $past(stat_q.esave)); // R10
  AST_BRET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (bret && !eret && !take) |=> stat_q.gie == $past(stat_q.bsave)); // R10
  AST_DBG_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_dbg) |=> stat_q.bsave == $past(stat_q.gie) && $stable(stat_q.esave)); // R4

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned NCAUSE     = 8,
  parameter int unsigned VEC_SHIFT  = 5,
  parameter int unsigned BASE_ALIGN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] exc_req,
  input  logic              irq_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic              eret,
  input  logic              bret,
  input  logic              csr_wr_en,
  input  logic [1:0]        csr_wr_sel,
  input  logic [XLEN-1:0]   csr_wr_data,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc,
  output logic [XLEN-1:0]   ea_out,
  output logic [XLEN-1:0]   ba_out,
  output logic [2:0]        status_out
);

  localparam int unsigned IDX_W = $clog2(NCAUSE);
  localparam logic [NCAUSE-1:0] REQ_KEEP =
    ~((NCAUSE'(1) << IDX_RESET) | (NCAUSE'(1) << IDX_IRQ));

  logic [NCAUSE-1:0] eff_req;
  logic              take, take_dbg;
  logic [IDX_W-1:0]  grant_idx;
  logic [XLEN-1:0]   nbase, dbase, vec_pc;
  logic              remap;
  stat_t             stat;
  logic              unused_req;

  logic              rv_q, rv_d;
  logic [XLEN-1:0]   rpc_q, rpc_d, ea_q, ea_d, ba_q, ba_d;
  logic              rpc_en, ea_en, ba_en;

  assign unused_req = exc_req[IDX_RESET] ^ exc_req[IDX_IRQ];

  for (genvar i = 0; i < NCAUSE; i++) begin : g_req
    if (i == IDX_RESET) begin : g_rst
      assign eff_req[i] = 1'b0;
    end else if (i == IDX_IRQ) begin : g_irq
      assign eff_req[i] = irq_in & stat.gie;
    end else begin : g_exc
      assign eff_req[i] = exc_req[i];
    end
  end

  trap_arbiter #(.NCAUSE(NCAUSE)) u_arb (
    .req       (eff_req),
    .grant_vld (take),
    .grant_idx (grant_idx)
  );

  assign take_dbg = (grant_idx == IDX_W'(IDX_BKPT)) || (grant_idx == IDX_W'(IDX_WATCH));

  trap_vector_calc #(.XLEN(XLEN), .NCAUSE(NCAUSE), .VEC_SHIFT(VEC_SHIFT)) u_vec (
    .idx    (grant_idx),
    .is_dbg (take_dbg),
    .remap  (remap),
    .nbase  (nbase),
    .dbase  (dbase),
    .vec_pc (vec_pc)
  );

  trap_csr_bank #(.XLEN(XLEN), .BASE_ALIGN(BASE_ALIGN)) u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (csr_wr_en),
    .wr_sel   (csr_wr_sel),
    .wr_data  (csr_wr_data),
    .take     (take),
    .take_dbg (take_dbg),
    .eret     (eret),
    .bret     (bret),
    .nbase    (nbase),
    .dbase    (dbase),
    .remap    (remap),
    .stat     (stat)
  );

  // next state
  always_comb begin
    rv_d   = take;
    rpc_en = take;
    ea_en  = take && !take_dbg;
    ba_en  = take && take_dbg;
    rpc_d  = vec_pc;
    ea_d   = pc_in;
    ba_d   = pc_in;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q  <= 1'b0;
      rpc_q <= '0;
      ea_q  <= '0;
      ba_q  <= '0;
    end else begin
      rv_q <= rv_d;
      if (rpc_en) rpc_q <= rpc_d;
      if (ea_en)  ea_q  <= ea_d;
      if (ba_en)  ba_q  <= ba_d;
    end
  end

  assign redirect_valid = rv_q;
  assign redirect_pc    = rpc_q;
  assign ea_out         = ea_q;
  assign ba_out         = ba_q;
  assign status_out     = stat;

  AST_EA_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_dbg) |=> ea_out == $past(pc_in) && $stable(ba_out)); // R1
  AST_BA_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_dbg) |=> ba_out == $past(pc_in) && $stable(ea_out)); // R2
  AST_GIE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> !status_out[0]); // R3
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> redirect_pc[VEC_SHIFT-1:0] == '0); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_out[0] && ((exc_req & REQ_KEEP) == '0)) |=> !redirect_valid); // R7
  AST_DBG_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_dbg) |=> redirect_pc[XLEN-1:BASE_ALIGN] == $past(dbase[XLEN-1:BASE_ALIGN])); // R6

endmodule

// File: tb/test_trap_entry_unit.sv
module test_trap_entry_unit;

  logic        clk, rst_n;
  logic [7:0]  exc_req;
  logic        irq_in, eret, bret, csr_wr_en;
  logic [31:0] pc_in, csr_wr_data;
  logic [1:0]  csr_wr_sel;
  logic        redirect_valid;
  logic [31:0] redirect_pc, ea_out, ba_out;
  logic [2:0]  status_out;

  int checks = 0, errors = 0;
  logic [31:0] m_nb, m_db, m_ea, m_ba;
  logic        m_remap, m_gie, m_es, m_bs;

  trap_entry_unit i_trap_entry_unit (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .irq_in(irq_in), .pc_in(pc_in),
    .eret(eret), .bret(bret), .csr_wr_en(csr_wr_en), .csr_wr_sel(csr_wr_sel),
    .csr_wr_data(csr_wr_data), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .ea_out(ea_out), .ba_out(ba_out), .status_out(status_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    exc_req = '0; irq_in = 0; eret = 0; bret = 0;
    csr_wr_en = 0; csr_wr_sel = '0; csr_wr_data = '0; pc_in = '0;
  endtask

  task automatic step(input string tag, input logic [7:0] req, input logic irq,
                      input logic er, input logic br, input logic wen,
                      input logic [1:0] wsel, input logic [31:0] wdata, input logic [31:0] pc);
    logic [7:0] eff;
    int idx;
    logic [31:0] base;
    @(negedge clk);
    exc_req = req; irq_in = irq; eret = er; bret = br;
    csr_wr_en = wen; csr_wr_sel = wsel; csr_wr_data = wdata; pc_in = pc;
    eff = req & 8'hBE;
    if (irq && m_gie) eff[6] = 1'b1;
    idx = -1;
    for (int i = 7; i >= 0; i--) if (eff[i]) idx = i;
    @(negedge clk);
    chk({tag, " valid"}, {31'd0, redirect_valid}, {31'd0, idx >= 0});
    if (idx >= 0) begin
      if (idx == 1 || idx == 3) begin
        base = m_db; m_ba = pc; m_bs = m_gie;
      end else begin
        base = m_remap ? m_db : m_nb; m_ea = pc; m_es = m_gie;
      end
      m_gie = 1'b0;
      chk({tag, " vector"}, redirect_pc, base + 32'(idx * 32));
    end else if (er) m_gie = m_es;
    else if (br) m_gie = m_bs;
    else if (wen && wsel == 2'd3) {m_bs, m_es, m_gie} = wdata[2:0];
    if (wen) begin
      case (wsel)
        2'd0: m_nb = wdata & 32'hFFFF_FF00;
        2'd1: m_db = wdata & 32'hFFFF_FF00;
        2'd2: m_remap = wdata[0];
        default: ;
      endcase
    end
    chk({tag, " ea"}, ea_out, m_ea);
    chk({tag, " ba"}, ba_out, m_ba);
    chk({tag, " status"}, {29'd0, status_out}, {29'd0, m_bs, m_es, m_gie});
    idle();
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    step("R12 write", 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, sel, d, 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    m_nb = 0; m_db = 0; m_ea = 0; m_ba = 0; m_remap = 0; m_gie = 0; m_es = 0; m_bs = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 valid", {31'd0, redirect_valid}, 32'd0);
    chk("R11 pc", redirect_pc, 32'd0);
    chk("R11 ea", ea_out, 32'd0);
    chk("R11 ba", ba_out, 32'd0);
    chk("R11 status", {29'd0, status_out}, 32'd0);
    rst_n = 1;

    wr(2'd0, 32'h1000_0000);
    wr(2'd1, 32'h2000_0000);

    // R1 R2 R3 R4 R5 R6 R7: every cause, both remap values, both enable values
    for (int rm = 0; rm < 2; rm++) begin
      for (int g = 0; g < 2; g++) begin
        for (int ix = 1; ix < 8; ix++) begin
          wr(2'd2, 32'(rm));
          wr(2'd3, {29'd0, (g == 1) ? 3'b001 : 3'b110});
          if (ix == 6)
            step("R7 irq", 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h4000_0000 + 32'(ix * 4));
          else if (ix == 1 || ix == 3)
            step("R2 R4 R6 debug", 8'(1 << ix), 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h5000_0000 + 32'(ix * 4 + rm * 64 + g * 32));
          else
            step("R1 R3 R5 R6 normal", 8'(1 << ix), 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h6000_0000 + 32'(ix * 4 + rm * 64 + g * 32));
        end
      end
    end

    // R8 R7: all request patterns, with and without the interrupt line
    wr(2'd2, 32'd0);
    for (int p = 0; p < 256; p++) begin
      for (int q = 0; q < 2; q++) begin
        wr(2'd3, {29'd0, 2'(p & 3), 1'b1});
        step("R8 R7 priority", 8'(p), q[0], 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 32'(p * 8 + q * 4));
      end
    end

    // R9: masking of base writes and write/request in the same cycle
    wr(2'd0, 32'hFFFF_FFFF);
    step("R9 mask", 8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0000_0abc);
    step("R9 same cycle", 8'h20, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 32'h3000_00ff, 32'h0000_0ac0);
    step("R9 next cycle", 8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0000_0ac4);
    wr(2'd1, 32'h7777_7777);
    step("R9 dbase mask", 8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0000_0b00);

    // R10: return strobes over every status value
    for (int s = 0; s < 8; s++) begin
      wr(2'd3, 32'(s));
      step("R10 eret", 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
      wr(2'd3, 32'(s));
      step("R10 bret", 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0, 32'h0);
      wr(2'd3, 32'(s));
      step("R10 both", 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 32'h0, 32'h0);
      wr(2'd3, 32'(s));
      step("R10 exc wins", 8'h80, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0000_0c00);
      wr(2'd3, 32'(s));
      step("R12 status vs exc", 8'h02, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 32'd7, 32'h0000_0d00);
      wr(2'd3, 32'(s));
      step("R12 status vs eret", 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 32'(~s & 7), 32'h0);
    end

    step("R5 idle", 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule